// File: doc/BRIEF.md
# Fiber Far-End Fault Signaling Unit

This block handles far-end fault signaling on a 100 Mb/s fiber port, working one bit per clock on the symbol stream. It combines three functions:

- **Transmit.** When the local signal-detect input reports that the fiber port is receiving nothing, the block fills the idle time between frames with a repeating fault marker. The marker is a run of ones closed by a single zero. Any bit the MAC is sending always takes precedence over the marker.
- **Receive.** The block scans the idle stream from the partner for the same marker. When it finds one, it raises a fault flag and holds the reported link down, even while the fiber signal itself is present. A received fault never alters what the block transmits.
- **Clearing.** The flag drops once a set number of marker-length idle windows pass with no new marker.

The signal-detect input arrives already classified into a two-bit level. A single control bit turns the whole fault mechanism off. That bit is low after reset, so signaling starts enabled. With signaling off, the link status follows signal-detect alone. Line coding, clock recovery and analog level sensing belong to neighbouring logic.

Top module: `fef_unit`

## Requirements
- R1: The level input is coded 2'b00 = copper mode, 2'b01 = fiber with no signal, 2'b10 or 2'b11 = fiber with signal. `link_up` can be high only for 2'b10/2'b11, and is high there whenever no received fault is in force.
- R2: With level 2'b01, signaling on and `tx_active` low, `tx_bit` repeats 84 ones followed by one zero. The first idle cycle after reset or after a frame carries the first of the ones.
- R3: While `tx_active` is high, `tx_bit` equals `tx_data` in the same cycle, whatever the fault state.
- R4: A frame that starts partway through the marker cuts it off at once. The next idle cycle begins a fresh marker from its first one.
- R5: In idle cycles with no local fault (level other than 2'b01), `tx_bit` is 1.
- R6: `fault_flag` rises one clock after an idle zero that ends a run of at least 84 idle ones. A run of 83 ones does not raise it. A cycle with `rx_active` high resets the run.
- R7: While `fault_flag` is high and signaling is on, `link_up` is low even at level 2'b10.
- R8: A received fault leaves the transmit stream unchanged: frames pass through, and idle bits stay 1 when there is no local fault.
- R9: `fault_flag` falls after CLR_PERIODS×85 idle cycles (170 by default) with no new marker, counted from the clock that raised it. Markers arriving closer together than that keep it high.
- R10: With `fault_sig_off` high, no marker is sent, `fault_flag` is cleared on the next clock and stays low, and `link_up` follows the level only. In copper mode no marker is detected.
- R11: During reset `fault_flag` is low and the marker position is at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sd_level | input | 2 | Classified signal-detect level |
| fault_sig_off | input | 1 | Control bit: 1 turns fault signaling off |
| tx_active | input | 1 | MAC is sending frame data |
| tx_data | input | 1 | MAC transmit bit |
| rx_active | input | 1 | Received stream is inside a frame |
| rx_data | input | 1 | Received bit |
| tx_bit | output | 1 | Bit sent to the line |
| link_up | output | 1 | Reported link status |
| fault_flag | output | 1 | A far-end fault is being received |

## Verification
A wrong marker position shows up on `tx_bit` within one 85-cycle period: the zero lands at the wrong offset, or it survives a frame boundary. A wrong run count or an early match raises `fault_flag` one clock after a zero that should have been ignored, and `link_up` drops in the same cycle. A wrong clearing counter moves the fall of `fault_flag` away from cycle 170, so the bench checks the flag on both sides of that edge.

// File: rtl/fef_pkg.sv
// Shared types for the far-end fault unit: the signal-detect level coding
// and the decoded per-mode view used by the top level.
package fef_pkg;
    typedef enum logic [1:0] {
        SD_COPPER     = 2'b00,
        SD_FIBER_DARK = 2'b01,
        SD_FIBER_LIT  = 2'b10,
        SD_FIBER_HI   = 2'b11
    } sd_level_e;

    typedef struct packed {
        logic copper;
        logic fiber_dark;
        logic fiber_lit;
    } sd_class_t;
endpackage

// File: rtl/fef_sd_classify.sv
// Decodes the two-bit signal-detect level into one-hot mode flags.
// Assumes the level is already synchronised to clk by the analog front end.
module fef_sd_classify
    import fef_pkg::*;
(
    input  logic [1:0] sd_level,
    output sd_class_t  cls
);
    // Map each level onto exactly one mode flag.
    always_comb begin
        cls = '0;
        unique case (sd_level)
            SD_COPPER:     cls.copper     = 1'b1;
            SD_FIBER_DARK: cls.fiber_dark = 1'b1;
            default:       cls.fiber_lit  = 1'b1;
        endcase
    end
endmodule

// File: rtl/fef_pattern_gen.sv
// Transmit side: inserts the ones-then-zero fault marker into idle cycles.
// Assumes tx_active marks every cycle that carries MAC data; MAC data is
// always passed through and restarts the marker from its first bit.
module fef_pattern_gen #(
    parameter int ONES_LEN = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic insert_en,
    input  logic tx_active,
    input  logic tx_data,
    output logic tx_bit
);
    localparam int PAT_LEN = ONES_LEN + 1;
    localparam int CW      = $clog2(PAT_LEN);
    localparam logic [CW-1:0] LAST = CW'(PAT_LEN - 1);

    logic [CW-1:0] pos;

    // Track the position inside the marker; frames and idle-off restart it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (tx_active || !insert_en) begin
            pos <= '0;
        end else if (pos == LAST) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Select frame data, marker bit or plain idle ones for the line.
    always_comb begin
        if (tx_active) begin
            tx_bit = tx_data;
        end else if (insert_en) begin
            tx_bit = (pos != LAST);
        end else begin
            tx_bit = 1'b1;
        end
    end
endmodule

// File: rtl/fef_pattern_det.sv
// Receive side: counts idle ones, declares a fault when a zero closes a run
// of at least ONES_LEN ones, and clears it after CLR_PERIODS marker lengths
// of idle time with no new marker. Assumes CLR_PERIODS >= 1.
module fef_pattern_det #(
    parameter int ONES_LEN    = 84,
    parameter int CLR_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic rx_active,
    input  logic rx_data,
    output logic fault_seen
);
    localparam int PAT_LEN    = ONES_LEN + 1;
    localparam int CLEAR_BITS = CLR_PERIODS * PAT_LEN;
    localparam int RW         = $clog2(ONES_LEN + 1);
    localparam int QW         = $clog2(CLEAR_BITS + 1);
    localparam logic [RW-1:0] RUN_FULL  = RW'(ONES_LEN);
    localparam logic [QW-1:0] QUIET_END = QW'(CLEAR_BITS - 1);

    logic [RW-1:0] run_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          hit;

    assign hit = det_en && !rx_active && !rx_data && (run_cnt == RUN_FULL);

    // Count consecutive idle ones, saturating at the marker length.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_en || rx_active) begin
            run_cnt <= '0;
        end else if (!rx_data) begin
            run_cnt <= '0;
        end else if (run_cnt != RUN_FULL) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Hold the fault flag and time its release over quiet idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !det_en) begin
            fault_seen <= 1'b0;
            quiet_cnt  <= '0;
        end else if (hit) begin
            fault_seen <= 1'b1;
            quiet_cnt  <= '0;
        end else if (fault_seen && !rx_active) begin
            if (quiet_cnt == QUIET_END) begin
                fault_seen <= 1'b0;
                quiet_cnt  <= '0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fef_unit.sv
// Top level of the far-end fault unit. Joins level decoding, marker
// insertion and marker detection, and derives the reported link status.
// Assumes all inputs are synchronous to clk, one line bit per cycle.
module fef_unit
    import fef_pkg::*;
#(
    parameter int ONES_LEN    = 84,
    parameter int CLR_PERIODS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sd_level,
    input  logic       fault_sig_off,
    input  logic       tx_active,
    input  logic       tx_data,
    input  logic       rx_active,
    input  logic       rx_data,
    output logic       tx_bit,
    output logic       link_up,
    output logic       fault_flag
);
    sd_class_t cls;
    logic      sig_on;
    logic      insert_en;
    logic      det_en;
    logic      fault_seen;

    fef_sd_classify u_cls (
        .sd_level (sd_level),
        .cls      (cls)
    );

    // Gate marker insertion and detection by the control bit and mode.
    always_comb begin
        sig_on    = !fault_sig_off;
        insert_en = sig_on && cls.fiber_dark;
        det_en    = sig_on && !cls.copper;
    end

    fef_pattern_gen #(.ONES_LEN(ONES_LEN)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .insert_en (insert_en),
        .tx_active (tx_active),
        .tx_data   (tx_data),
        .tx_bit    (tx_bit)
    );

    fef_pattern_det #(.ONES_LEN(ONES_LEN), .CLR_PERIODS(CLR_PERIODS)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_en     (det_en),
        .rx_active  (rx_active),
        .rx_data    (rx_data),
        .fault_seen (fault_seen)
    );

    // Report link only for a lit fiber with no received fault in force.
    always_comb begin
        link_up    = cls.fiber_lit && !(sig_on && fault_seen);
        fault_flag = fault_seen;
    end
endmodule

// File: rtl/fef_unit_chk.sv
// Port-level property checker for fef_unit, attached by bind below.
module fef_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sd_level,
    input logic       fault_sig_off,
    input logic       tx_active,
    input logic       tx_data,
    input logic       rx_active,
    input logic       rx_data,
    input logic       tx_bit,
    input logic       link_up,
    input logic       fault_flag
);
    AST_DATA_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> (tx_bit == tx_data)); // R3
    AST_LINK_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> sd_level[1]); // R1
    AST_FAULT_FORCES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_sig_off) |-> !link_up); // R7
    AST_RISE_ON_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> ($past(!rx_data) && $past(!rx_active))); // R6
    AST_OFF_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sig_off |=> !fault_flag); // R10
    AST_OFF_NO_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_sig_off && !tx_active) |-> tx_bit); // R10
    AST_IDLE_ONES_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && sd_level != 2'b01) |-> tx_bit); // R5
endmodule

bind fef_unit fef_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sd_level      (sd_level),
    .fault_sig_off (fault_sig_off),
    .tx_active     (tx_active),
    .tx_data       (tx_data),
    .rx_active     (rx_active),
    .rx_data       (rx_data),
    .tx_bit        (tx_bit),
    .link_up       (link_up),
    .fault_flag    (fault_flag)
);

// File: tb/tb_fef_unit.sv
// Self-checking bench for fef_unit: a vector table, then directed tests.
module tb_fef_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sd_level = 2'b00;
    logic       fault_sig_off = 1'b0;
    logic       tx_active = 1'b0;
    logic       tx_data = 1'b0;
    logic       rx_active = 1'b0;
    logic       rx_data = 1'b1;
    logic       tx_bit, link_up, fault_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fef_unit dut (
        .clk(clk), .rst_n(rst_n), .sd_level(sd_level),
        .fault_sig_off(fault_sig_off), .tx_active(tx_active),
        .tx_data(tx_data), .rx_active(rx_active), .rx_data(rx_data),
        .tx_bit(tx_bit), .link_up(link_up), .fault_flag(fault_flag)
    );

    // Vector fields: {sd[1:0], off, tx_active, tx_data, exp_link, exp_tx}
    localparam logic [6:0] VEC [8] = '{
        7'b00_0_00_0_1, // R1 R5 copper
        7'b01_0_00_0_1, // R1 R2 dark, marker starts with a one
        7'b10_0_00_1_1, // R1 lit
        7'b11_0_00_1_1, // R1 lit high
        7'b10_1_00_1_1, // R10 off, lit
        7'b01_1_00_0_1, // R10 off, dark
        7'b10_0_10_1_0, // R3 frame bit
        7'b01_0_10_0_0  // R3 frame over local fault
    };

    task automatic chk(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    // Sample n idle cycles and compare with a marker starting at its first one.
    task automatic grab_marker(input int n, input string tag);
        int bad = 0;
        int first_i = -1;
        int first_v = 0;
        for (int i = 0; i < n; i++) begin
            if (tx_bit != ((i % 85) != 84)) begin
                bad++;
                if (first_i < 0) begin first_i = i; first_v = tx_bit; end
            end
            @(negedge clk); #1;
        end
        if (bad != 0) $display("  first bad bit %0d value %0d", first_i, first_v);
        chk(bad, 0, tag);
    endtask

    // Clear the run with one frame cycle, then n idle ones and a zero.
    task automatic send_marker(input int n);
        @(negedge clk); rx_active = 1'b1; rx_data = 1'b1;
        @(negedge clk); rx_active = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_data = 1'b1; @(negedge clk);
        end
        rx_data = 1'b0; @(negedge clk);
        rx_data = 1'b1; #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Vector table walk
        for (int v = 0; v < 8; v++) begin
            rst_n = 1'b0;
            {sd_level, fault_sig_off, tx_active, tx_data} = VEC[v][6:2];
            @(negedge clk); @(negedge clk);
            rst_n = 1'b1; #1;
            chk(link_up, VEC[v][1], $sformatf("R1 vec%0d link", v));
            chk(tx_bit,  VEC[v][0], $sformatf("R5 vec%0d tx", v));
        end

        // R11: reset state
        sd_level = 2'b10; fault_sig_off = 1'b0; tx_active = 1'b0;
        rst_n = 1'b0; @(negedge clk); #1;
        chk(fault_flag, 0, "R11 flag in reset");
        chk(link_up, 1, "R11 link in reset");

        // R2: marker generation over two periods
        sd_level = 2'b01;
        do_reset();
        grab_marker(170, "R2 marker");

        // R3/R4: frame cuts into marker, marker restarts afterwards
        repeat (40) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            tx_active = 1'b1; tx_data = i[0]; #1;
            chk(tx_bit, i[0], "R3 frame passthrough");
            @(negedge clk);
        end
        tx_active = 1'b0; #1;
        grab_marker(85, "R4 restart after frame");

        // R6: 83 ones is not enough, 84 is
        sd_level = 2'b10;
        do_reset();
        send_marker(83);
        chk(fault_flag, 0, "R6 83 ones ignored");
        send_marker(84);
        chk(fault_flag, 1, "R6 84 ones detected");
        chk(link_up, 0, "R7 link down with signal");

        // R8: transmit untouched by received fault
        chk(tx_bit, 1, "R8 idle stays one");
        tx_active = 1'b1; tx_data = 1'b0; #1;
        chk(tx_bit, 0, "R8 frame zero passes");
        tx_data = 1'b1; #1;
        chk(tx_bit, 1, "R8 frame one passes");
        tx_active = 1'b0;

        // R9: repeated markers hold the flag
        for (int k = 0; k < 3; k++) begin
            send_marker(84);
            chk(fault_flag, 1, "R9 held by markers");
        end

        // R9: release exactly after 170 quiet idle cycles
        rx_data = 1'b1;
        repeat (169) @(negedge clk);
        #1;
        chk(fault_flag, 1, "R9 still set at 169");
        @(negedge clk); #1;
        chk(fault_flag, 0, "R9 cleared at 170");
        chk(link_up, 1, "R9 link restored");

        // R6: frame cycle inside a run resets it
        @(negedge clk); rx_active = 1'b1;
        @(negedge clk); rx_active = 1'b0;
        repeat (50) @(negedge clk);
        rx_active = 1'b1; @(negedge clk); rx_active = 1'b0;
        repeat (40) @(negedge clk);
        rx_data = 1'b0; @(negedge clk); rx_data = 1'b1; #1;
        chk(fault_flag, 0, "R6 interrupted run ignored");

        // R10: turning off drops link gating, then the flag
        send_marker(84);
        chk(fault_flag, 1, "R10 flag set before off");
        fault_sig_off = 1'b1; #1;
        chk(link_up, 1, "R10 link follows level when off");
        @(negedge clk); #1;
        chk(fault_flag, 0, "R10 flag cleared when off");
        send_marker(84);
        chk(fault_flag, 0, "R10 detection ignored when off");

        // R10: no marker while off, even with no signal
        sd_level = 2'b01;
        do_reset();
        begin
            int zeros = 0;
            for (int i = 0; i < 170; i++) begin
                if (tx_bit == 1'b0) zeros++;
                @(negedge clk); #1;
            end
            chk(zeros, 0, "R10 no marker when off");
        end

        // R10: copper mode never detects
        fault_sig_off = 1'b0; sd_level = 2'b00;
        do_reset();
        send_marker(84);
        chk(fault_flag, 0, "R10 copper no detect");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule